// File: doc/BRIEF.md
# Two-Level IO Address Translator

This block turns the addresses that IO devices present for DMA into real memory addresses. The IO address space is cut into 256 MB segments. A segment table in memory holds one 64-bit descriptor per segment, and each valid descriptor points at that segment's page table. The translator reads the segment descriptor, then the page entry, through a simple request/response memory port. It then either returns the translated real address or reports whether the failure came from the segment level or the page level.

Each segment descriptor picks its own page size from 4 KB, 64 KB, 1 MB or 16 MB. The page size sets how many IO address bits index the page table and how many pass straight through as the in-page offset. Two software-written control words govern operation: a table-origin word, which holds the table base, the highest legal segment index and an enable bit, and a configuration word holding a global translate-enable bit. When either enable is clear, requests pass through untranslated.

Only one request is handled at a time. The mode, the table origin and the segment limit are all taken at the moment a request is accepted.

Top module: `iox_translator`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, and both control words read as zero, so translation is off.
- R2: If the origin enable (origin word bit 63) or the translate enable (config word bit 0) is clear when a request is accepted, `rsp_valid` rises in the cycle after acceptance with `rsp_addr` equal to the zero-extended IO address, `rsp_kind` 0, and no memory access.
- R3: The segment index is IO address bits 35:28. An index greater than origin word bits 7:0 gives `rsp_kind` 1 (segment fault) with no memory access. An index equal to the limit is legal.
- R4: The descriptor fetch address is (origin bits 41:12) × 4096 + index × 8. The page-entry fetch address is (descriptor bits 41:12) × 4096 + page index × 8. Every fetch address is 8-byte aligned.
- R5: A descriptor with bit 63 clear, or with a page-size code (bits 2:0) outside {1, 3, 5, 7}, gives a segment fault with no page-entry fetch.
- R6: Page-size codes 1, 3, 5 and 7 select page shifts of 12, 16, 20 and 24. The page index is IO address bits 27 down to the shift.
- R7: If (page index >> 9) exceeds descriptor bits 11:5 (table length in 4 KB pages minus one), the result is a page fault (`rsp_kind` 2) with no page-entry fetch.
- R8: A read needs page-entry bit 63 and a write needs bit 62. A missing permission gives a page fault.
- R9: Page-entry bits 10:0 must equal the request's requester ID, otherwise the result is a page fault.
- R10: On success, `rsp_addr` is page-entry bits 41 down to the page shift, followed by the IO address bits below the shift.
- R11: `mem_req_valid` stays high with a stable address until `mem_req_ready`. At most one fetch is outstanding, and `req_ready` stays low from acceptance until the cycle after `rsp_valid`.
- R12: `reg_sel` 0 writes the origin word and 1 writes the config word. A write in the same cycle as an acceptance does not affect that request, only later ones.
- R13: `rsp_valid` is a single-cycle pulse. `rsp_kind` is 0 for success, 1 for a segment fault and 2 for a page fault, and `rsp_addr` is 0 on a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_sel | input | 1 | 0: origin word, 1: config word |
| reg_wdata | input | 64 | Control word write data |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Translator idle, request accepted |
| req_addr | input | IOA_W | IO address |
| req_write | input | 1 | 1 for a write access |
| req_rid | input | RID_W | Requester ID |
| rsp_valid | output | 1 | Result pulse |
| rsp_addr | output | RA_W | Translated real address |
| rsp_kind | output | 2 | 0 ok, 1 segment fault, 2 page fault |
| mem_req_valid | output | 1 | Table fetch request |
| mem_req_ready | input | 1 | Memory accepts fetch |
| mem_req_addr | output | RA_W | Fetch address |
| mem_rsp_valid | input | 1 | Fetched word present |
| mem_rsp_data | input | 64 | Fetched 64-bit word |

## Verification
A control word write and a request acceptance can fall in the same clock edge. The bench provokes this by raising `reg_wr` to clear translate-enable in the same cycle as `req_valid`, while translation is active. The request must still come back fully translated, and the very next request must come back in pass-through form. Memory back-pressure, with `mem_req_ready` toggling each cycle during a walk, is run against the same expected address, to show that a stalled fetch does not change its result.

// File: rtl/iox_pkg.sv
package iox_pkg;
  // Segment geometry: a segment spans 2**SEG_SHIFT bytes.
  localparam int SEG_SHIFT      = 28;
  localparam int MIN_PAGE_SHIFT = 12;
  localparam int SHIFT_STEP     = 4;
  localparam int NUM_SIZES      = 4;
  localparam int PIDX_W         = SEG_SHIFT - MIN_PAGE_SHIFT;
  // Eight-byte entries, so one 4 KB table page holds 2**ENT_PER_PG_LOG entries.
  localparam int ENT_PER_PG_LOG = 9;
  localparam int LEN_W          = 7;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_SEG  = 2'd1,
    K_PAGE = 2'd2
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_STE_REQ,
    S_STE_WAIT,
    S_PTE_REQ,
    S_PTE_WAIT,
    S_DONE
  } state_e;

  // Legal size codes are the odd ones; bits 2:1 then select the size.
  function automatic logic size_code_legal(input logic [2:0] code);
    return code[0];
  endfunction
endpackage

// File: rtl/iox_ctrl_regs.sv
module iox_ctrl_regs #(
  parameter int RA_W  = 42,
  parameter int SEG_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_sel,
  input  logic [63:0]         wr_data,
  output logic                org_en,
  output logic [RA_W-13:0]    org_page,
  output logic [SEG_W-1:0]    org_last,
  output logic                xl_en
);
  logic             org_en_q, org_en_d;
  logic [RA_W-13:0] org_page_q, org_page_d;
  logic [SEG_W-1:0] org_last_q, org_last_d;
  logic             xl_en_q, xl_en_d;
  logic             org_ld, cfg_ld;

  assign org_ld = wr_en && !wr_sel;
  assign cfg_ld = wr_en &&  wr_sel;

  always_comb begin
    org_en_d   = wr_data[63];
    org_page_d = wr_data[RA_W-1:12];
    org_last_d = wr_data[SEG_W-1:0];
    xl_en_d    = wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      org_en_q   <= 1'b0;
      org_page_q <= '0;
      org_last_q <= '0;
      xl_en_q    <= 1'b0;
    end else begin
      if (org_ld) begin
        org_en_q   <= org_en_d;
        org_page_q <= org_page_d;
        org_last_q <= org_last_d;
      end
      if (cfg_ld) begin
        xl_en_q <= xl_en_d;
      end
    end
  end

  assign org_en   = org_en_q;
  assign org_page = org_page_q;
  assign org_last = org_last_q;
  assign xl_en    = xl_en_q;

  logic unused_wdata;
  assign unused_wdata = ^{wr_data[62:RA_W], wr_data[11:SEG_W]};
endmodule

// File: rtl/iox_ste_decode.sv
module iox_ste_decode #(
  parameter int RA_W = 42
) (
  input  logic [63:0]                      ste,
  input  logic [iox_pkg::SEG_SHIFT-1:0]    seg_off,
  output logic                             seg_bad,
  output logic                             len_bad,
  output logic [RA_W-1:0]                  pte_addr,
  output logic [1:0]                       size_sel
);
  import iox_pkg::*;

  logic [PIDX_W-1:0] pidx_by_size [NUM_SIZES];
  logic [PIDX_W-1:0] pidx;
  logic [LEN_W-1:0]  tbl_page;

  // One page-index extractor per supported page size.
  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    localparam int SH = MIN_PAGE_SHIFT + SHIFT_STEP * g;
    assign pidx_by_size[g] = PIDX_W'(seg_off[SEG_SHIFT-1:SH]);
  end

  assign size_sel = ste[2:1];
  assign pidx     = pidx_by_size[size_sel];
  assign tbl_page = pidx[PIDX_W-1:ENT_PER_PG_LOG];

  assign seg_bad  = !ste[63] || !size_code_legal(ste[2:0]);
  assign len_bad  = tbl_page > ste[11:5];
  assign pte_addr = {ste[RA_W-1:12], 12'h000} + RA_W'({pidx, 3'b000});

  logic unused_ste;
  assign unused_ste = ^{ste[62:RA_W], ste[4:3]};
endmodule

// File: rtl/iox_pte_check.sv
module iox_pte_check #(
  parameter int RA_W  = 42,
  parameter int RID_W = 11
) (
  input  logic [63:0]                   pte,
  input  logic [iox_pkg::SEG_SHIFT-1:0] seg_off,
  input  logic [1:0]                    size_sel,
  input  logic                          is_wr,
  input  logic [RID_W-1:0]              rid,
  output logic                          deny,
  output logic [RA_W-1:0]               ra
);
  import iox_pkg::*;

  logic [RA_W-1:0] ra_by_size [NUM_SIZES];
  logic            perm_ok, id_ok;

  // Real page bits above the shift, IO offset bits below it.
  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    localparam int SH = MIN_PAGE_SHIFT + SHIFT_STEP * g;
    assign ra_by_size[g] = {pte[RA_W-1:SH], seg_off[SH-1:0]};
  end

  assign ra      = ra_by_size[size_sel];
  assign perm_ok = is_wr ? pte[62] : pte[63];
  assign id_ok   = pte[RID_W-1:0] == rid;
  assign deny    = !(perm_ok && id_ok);

  logic unused_pte;
  assign unused_pte = ^{pte[61:RA_W], pte[11:RID_W], seg_off[SEG_SHIFT-1:24]};
endmodule

// File: rtl/iox_translator.sv
module iox_translator #(
  parameter int IOA_W = 36,
  parameter int RA_W  = 42,
  parameter int RID_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [63:0]       reg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IOA_W-1:0]  req_addr,
  input  logic              req_write,
  input  logic [RID_W-1:0]  req_rid,
  output logic              rsp_valid,
  output logic [RA_W-1:0]   rsp_addr,
  output logic [1:0]        rsp_kind,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [RA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data
);
  import iox_pkg::*;

  localparam int SEG_W = IOA_W - SEG_SHIFT;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  // Control words
  logic             org_en, xl_en;
  logic [RA_W-13:0] org_page;
  logic [SEG_W-1:0] org_last;

  iox_ctrl_regs #(.RA_W(RA_W), .SEG_W(SEG_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_en    (reg_wr),
    .wr_sel   (reg_sel),
    .wr_data  (reg_wdata),
    .org_en   (org_en),
    .org_page (org_page),
    .org_last (org_last),
    .xl_en    (xl_en)
  );

  // Walk state
  state_e            state_q, state_d;
  logic [IOA_W-1:0]  ioa_q;
  logic              wr_q;
  logic [RID_W-1:0]  rid_q;
  logic [RA_W-1:0]   addr_q, addr_d;
  logic [1:0]        sel_q, sel_d;
  logic [RA_W-1:0]   res_addr_q, res_addr_d;
  kind_e             res_kind_q, res_kind_d;
  logic              req_ld, addr_ld, sel_ld, res_ld;

  logic [SEG_W-1:0]  seg_idx;
  assign seg_idx = req_addr[IOA_W-1:SEG_SHIFT];

  // Descriptor decode and page-entry check
  logic            ste_seg_bad, ste_len_bad;
  logic [RA_W-1:0] ste_pte_addr;
  logic [1:0]      ste_size_sel;

  iox_ste_decode #(.RA_W(RA_W)) u_ste (
    .ste      (mem_rsp_data),
    .seg_off  (ioa_q[SEG_SHIFT-1:0]),
    .seg_bad  (ste_seg_bad),
    .len_bad  (ste_len_bad),
    .pte_addr (ste_pte_addr),
    .size_sel (ste_size_sel)
  );

  logic            pte_deny;
  logic [RA_W-1:0] pte_ra;

  iox_pte_check #(.RA_W(RA_W), .RID_W(RID_W)) u_pte (
    .pte      (mem_rsp_data),
    .seg_off  (ioa_q[SEG_SHIFT-1:0]),
    .size_sel (sel_q),
    .is_wr    (wr_q),
    .rid      (rid_q),
    .deny     (pte_deny),
    .ra       (pte_ra)
  );

  // Next-state logic
  always_comb begin
    state_d    = state_q;
    addr_d     = addr_q;
    sel_d      = ste_size_sel;
    res_addr_d = res_addr_q;
    res_kind_d = res_kind_q;
    req_ld     = 1'b0;
    addr_ld    = 1'b0;
    sel_ld     = 1'b0;
    res_ld     = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (req_valid) begin
          req_ld = 1'b1;
          if (!(org_en && xl_en)) begin
            res_ld     = 1'b1;
            res_addr_d = RA_W'(req_addr);
            res_kind_d = K_NONE;
            state_d    = S_DONE;
          end else if (seg_idx > org_last) begin
            res_ld     = 1'b1;
            res_addr_d = '0;
            res_kind_d = K_SEG;
            state_d    = S_DONE;
          end else begin
            addr_ld = 1'b1;
            addr_d  = {org_page, 12'h000} + RA_W'({seg_idx, 3'b000});
            state_d = S_STE_REQ;
          end
        end
      end
      S_STE_REQ: begin
        if (mem_req_ready) state_d = S_STE_WAIT;
      end
      S_STE_WAIT: begin
        if (mem_rsp_valid) begin
          if (ste_seg_bad) begin
            res_ld     = 1'b1;
            res_addr_d = '0;
            res_kind_d = K_SEG;
            state_d    = S_DONE;
          end else if (ste_len_bad) begin
            res_ld     = 1'b1;
            res_addr_d = '0;
            res_kind_d = K_PAGE;
            state_d    = S_DONE;
          end else begin
            addr_ld = 1'b1;
            sel_ld  = 1'b1;
            addr_d  = ste_pte_addr;
            state_d = S_PTE_REQ;
          end
        end
      end
      S_PTE_REQ: begin
        if (mem_req_ready) state_d = S_PTE_WAIT;
      end
      S_PTE_WAIT: begin
        if (mem_rsp_valid) begin
          res_ld  = 1'b1;
          state_d = S_DONE;
          if (pte_deny) begin
            res_addr_d = '0;
            res_kind_d = K_PAGE;
          end else begin
            res_addr_d = pte_ra;
            res_kind_d = K_NONE;
          end
        end
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q    <= S_IDLE;
      ioa_q      <= '0;
      wr_q       <= 1'b0;
      rid_q      <= '0;
      addr_q     <= '0;
      sel_q      <= '0;
      res_addr_q <= '0;
      res_kind_q <= K_NONE;
    end else begin
      state_q <= state_d;
      if (req_ld) begin
        ioa_q <= req_addr;
        wr_q  <= req_write;
        rid_q <= req_rid;
      end
      if (addr_ld) addr_q <= addr_d;
      if (sel_ld)  sel_q  <= sel_d;
      if (res_ld) begin
        res_addr_q <= res_addr_d;
        res_kind_q <= res_kind_d;
      end
    end
  end

  assign req_ready     = state_q == S_IDLE;
  assign mem_req_valid = (state_q == S_STE_REQ) || (state_q == S_PTE_REQ);
  assign mem_req_addr  = addr_q;
  assign rsp_valid     = state_q == S_DONE;
  assign rsp_addr      = res_addr_q;
  assign rsp_kind      = res_kind_q;
endmodule

// File: rtl/iox_translator_chk.sv
module iox_translator_chk #(
  parameter int RA_W = 42
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic [1:0]      rsp_kind,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [RA_W-1:0] mem_req_addr
);
  // R11: a stalled fetch keeps its request and address
  a_r11_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R11: no new request is taken while a fetch is pending
  a_r11_busy_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  // R11: acceptance closes the request side for the next cycle
  a_r11_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R4: table fetches are eight-byte aligned
  a_r4_fetch_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[2:0] == 3'b000);

  // R13: the result is a single-cycle pulse
  a_r13_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R13: only the three defined result kinds appear
  a_r13_kind_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_kind != 2'd3);

  // R11: a result and a fetch never coexist
  a_r11_rsp_not_fetching: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !mem_req_valid);
endmodule

bind iox_translator iox_translator_chk #(.RA_W(RA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .rsp_kind      (rsp_kind),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr)
);

// File: tb/iox_translator_test.sv
module iox_translator_test;
  localparam int CLK_PERIOD = 10;
  localparam int IOA_W = 36;
  localparam int RA_W  = 42;
  localparam int RID_W = 11;

  logic              clk;
  logic              rst_n;
  logic              reg_wr, reg_sel;
  logic [63:0]       reg_wdata;
  logic              req_valid, req_ready, req_write;
  logic [IOA_W-1:0]  req_addr;
  logic [RID_W-1:0]  req_rid;
  logic              rsp_valid;
  logic [RA_W-1:0]   rsp_addr;
  logic [1:0]        rsp_kind;
  logic              mem_req_valid, mem_req_ready;
  logic [RA_W-1:0]   mem_req_addr;
  logic              mem_rsp_valid;
  logic [63:0]       mem_rsp_data;

  iox_translator #(.IOA_W(IOA_W), .RA_W(RA_W), .RID_W(RID_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_rid(req_rid),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_kind(rsp_kind),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad   = 0;
  int wd_cycles = 0;
  bit finished = 0;

  // Backing memory for the tables
  logic [63:0] bmem [logic [RA_W-1:0]];
  logic [RA_W-1:0] mem_log [8];
  int  mem_acc = 0;
  bit  stall = 0;
  bit  pend = 0;
  int  lat = 0;
  logic [RA_W-1:0] pend_addr;

  // Memory responder: works on falling edges
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = 64'h0;
      mem_req_ready = 1'b0;
      pend = 0;
    end else begin
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (lat == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = bmem.exists(pend_addr) ? bmem[pend_addr] : 64'h0;
          pend = 0;
        end else begin
          lat--;
        end
      end
      mem_req_ready = stall ? ~mem_req_ready : 1'b1;
      if (mem_req_valid && mem_req_ready && !pend) begin
        pend = 1;
        lat  = 1;
        pend_addr = mem_req_addr;
        mem_log[mem_acc % 8] = mem_req_addr;
        mem_acc++;
      end
    end
  end

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    wd_cycles++;
    if (wd_cycles > 20000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=<20000", wd_cycles);
      report();
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic wr_reg(input logic sel, input logic [63:0] val);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  logic [RA_W-1:0] o_addr;
  logic [1:0]      o_kind;
  int              o_cyc, o_acc, o_first;

  task automatic do_xlate(input logic [IOA_W-1:0] a, input logic w, input logic [RID_W-1:0] id,
                          input bit cfg_now, input logic [63:0] cfg_val);
    int cyc;
    o_first = mem_acc;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_rid = id;
    if (cfg_now) begin
      reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = cfg_val;
    end
    @(negedge clk);
    req_valid = 1'b0; reg_wr = 1'b0;
    cyc = 1;
    while (!rsp_valid && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    o_addr = rsp_addr;
    o_kind = rsp_kind;
    o_cyc  = cyc;
    @(negedge clk);
    chk_eq("R13 rsp_valid single pulse", 64'(rsp_valid), 64'd0);
    o_acc = mem_acc - o_first;
  endtask

  // Scenario tasks
  task automatic t_reset();
    chk_eq("R1 req_ready after reset", 64'(req_ready), 64'd1);
    chk_eq("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    chk_eq("R1 mem_req_valid after reset", 64'(mem_req_valid), 64'd0);
    do_xlate(36'h0_0000_5123, 1'b0, 11'h12, 0, 64'h0);
    chk_eq("R1 reset state passes through", 64'(o_addr), 64'h5123);
    chk_eq("R2 bypass latency one cycle", 64'(o_cyc), 64'd1);
    chk_eq("R2 bypass no memory access", 64'(o_acc), 64'd0);
  endtask

  task automatic t_te_off();
    do_xlate(36'h0_0000_5123, 1'b0, 11'h12, 0, 64'h0);
    chk_eq("R2 origin on, translate off: address", 64'(o_addr), 64'h5123);
    chk_eq("R2 origin on, translate off: kind", 64'(o_kind), 64'd0);
    chk_eq("R2 origin on, translate off: no fetch", 64'(o_acc), 64'd0);
  endtask

  task automatic t_walk_4k(input string tag);
    do_xlate(36'h0_0000_5123, 1'b0, 11'h12, 0, 64'h0);
    chk_eq({tag, " R10 4K address"}, 64'(o_addr), 64'hABCDE123);
    chk_eq({tag, " R13 kind ok"}, 64'(o_kind), 64'd0);
    chk_eq({tag, " R4 two fetches"}, 64'(o_acc), 64'd2);
    chk_eq({tag, " R4 descriptor address"}, 64'(mem_log[o_first % 8]), 64'h100000);
    chk_eq({tag, " R6 entry address"}, 64'(mem_log[(o_first + 1) % 8]), 64'h200028);
  endtask

  task automatic t_write_denied();
    do_xlate(36'h0_0000_5123, 1'b1, 11'h12, 0, 64'h0);
    chk_eq("R8 write without permission kind", 64'(o_kind), 64'd2);
    chk_eq("R13 fault address zero", 64'(o_addr), 64'd0);
  endtask

  task automatic t_rid_mismatch();
    do_xlate(36'h0_0000_5123, 1'b0, 11'h13, 0, 64'h0);
    chk_eq("R9 requester mismatch kind", 64'(o_kind), 64'd2);
  endtask

  task automatic t_seg_limit();
    do_xlate(36'h0_5000_0000, 1'b0, 11'h12, 0, 64'h0);
    chk_eq("R3 index beyond limit kind", 64'(o_kind), 64'd1);
    chk_eq("R3 index beyond limit no fetch", 64'(o_acc), 64'd0);
  endtask

  task automatic t_ste_bad();
    do_xlate(36'h0_1000_0000, 1'b0, 11'h12, 0, 64'h0);
    chk_eq("R5 invalid descriptor kind", 64'(o_kind), 64'd1);
    chk_eq("R5 invalid descriptor one fetch", 64'(o_acc), 64'd1);
    do_xlate(36'h0_2000_0000, 1'b0, 11'h12, 0, 64'h0);
    chk_eq("R5 illegal size code kind", 64'(o_kind), 64'd1);
    chk_eq("R5 illegal size code one fetch", 64'(o_acc), 64'd1);
  endtask

  task automatic t_big_page();
    do_xlate(36'h0_3A12_3456, 1'b1, 11'h003, 0, 64'h0);
    chk_eq("R10 16M address", 64'(o_addr), 64'h5123456);
    chk_eq("R3 index equal to limit accepted", 64'(o_kind), 64'd0);
    chk_eq("R6 16M entry address", 64'(mem_log[(o_first + 1) % 8]), 64'h300050);
  endtask

  task automatic t_length();
    do_xlate(36'h0_0020_0000, 1'b0, 11'h12, 0, 64'h0);
    chk_eq("R7 index past table length kind", 64'(o_kind), 64'd2);
    chk_eq("R7 no entry fetch", 64'(o_acc), 64'd1);
  endtask

  task automatic t_stall();
    stall = 1;
    t_walk_4k("R11 stalled");
    stall = 0;
  endtask

  task automatic t_same_cycle();
    do_xlate(36'h0_0000_5123, 1'b0, 11'h12, 1, 64'h0);
    chk_eq("R12 same-cycle write ignored by request", 64'(o_addr), 64'hABCDE123);
    chk_eq("R12 same-cycle request walked", 64'(o_acc), 64'd2);
    do_xlate(36'h9_8765_4321, 1'b1, 11'h0, 0, 64'h0);
    chk_eq("R12 next request sees translate off", 64'(o_addr), 64'h9_8765_4321);
    chk_eq("R2 wide bypass no fetch", 64'(o_acc), 64'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = 64'h0;
    req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_rid = '0;
    // Segment table at 0x100000, limit 3
    bmem[42'h100000] = 64'h8000_0000_0020_0001; // seg 0: 4K pages, table at 0x200000, one page
    bmem[42'h100010] = 64'h8000_0000_0040_0002; // seg 2: illegal size code
    bmem[42'h100018] = 64'h8000_0000_0030_0007; // seg 3: 16M pages, table at 0x300000
    bmem[42'h200028] = 64'h8000_0000_ABCD_E012; // read only, id 0x12
    bmem[42'h300050] = 64'hC000_0000_0500_0003; // read/write, id 0x3
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    t_reset();
    wr_reg(1'b0, 64'h8000_0000_0010_0003);
    t_te_off();
    wr_reg(1'b1, 64'h1);
    t_walk_4k("R4");
    t_write_denied();
    t_rid_mismatch();
    t_seg_limit();
    t_ste_bad();
    t_big_page();
    t_length();
    t_stall();
    t_same_cycle();

    repeat (3) @(negedge clk);
    report();
  end
endmodule